// File: doc/BRIEF.md
# Inbound Address Window Translator

This block implements one inbound memory window of a translation unit that sits between an external bus and an internal bus. It holds three configuration registers, reached through a small register port: a window base, a window limit that doubles as a size mask, and a translation target. For every memory cycle address presented on the cycle port, the block decides whether the window claims that cycle. It also forms the internal-bus address that the transfer should use.

The limit register controls which base bits can be written. A base bit whose limit bit is 0 is read-only and reads as 0. A base bit whose limit bit is 1 can be read and written. The number of zero bits in the limit therefore sets the power-of-two window size, with a minimum granule of 4 KB. Bit 0 of the limit register is a claim-off flag: while it is set, the window never claims, even if a base has been assigned. The claim decision and the translated address are both registered and appear one clock after the cycle strobe.

Top module: `inbound_window_xlate`

## Requirements
- R1: After a synchronous reset, the base register reads 0x00000000, the limit register reads 0xFF000000 (a 16 MB window with claiming enabled), and the translation register reads 0x00000000.
- R2: A write to the base register (select code 0) stores a bit in 31:12 only where the limit bit is 1. A base read returns the stored bits ANDed with limit bits 31:12, and bits 11:0 always read 0.
- R3: While limit bits 31:12 are all zero, a base write has no visible effect (the base reads 0), and the window claims no cycle.
- R4: For the limit register (select code 1), bits 31:12 and bit 0 are read/write. Bits 11:1 read 0 and ignore written data.
- R5: When `cyc_valid` is high and the masked address bits 31:12 equal the masked base bits, with a nonzero limit mask and the claim-off bit clear, `claim` is 1 in the following cycle. In every other case `claim` is 0 in the following cycle.
- R6: While limit bit 0 is 1, `claim` stays 0 for every cycle address.
- R7: One clock after `cyc_valid`, `xlat_addr` equals (translation AND mask) OR (cycle address AND NOT mask). Here the mask is limit bits 31:12 with bits 11:0 taken as 0, so address bits 11:0 always pass through unchanged.
- R8: The translation register (select code 2) stores bits 31:12 and reads 0 in bits 11:0. Its bits below the limit mask have no effect on `xlat_addr`.
- R9: When a register write and a cycle strobe occur in the same clock, the cycle is decoded and translated with the register values from before that write.
- R10: Select code 3 reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 base, 1 limit, 2 translation, 3 unused |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_sel` |
| cyc_valid | input | 1 | Memory cycle address strobe |
| cyc_addr | input | 32 | Memory cycle address |
| claim | output | 1 | Window claims the cycle strobed one clock earlier |
| xlat_addr | output | 32 | Translated address for the cycle strobed one clock earlier |

## Verification
Two functions can fall in the same clock: a register update on the register port and an address decode on the cycle port. The bench provokes this by writing the base register and strobing an address that only the new base would hit. It does the same with writes to the limit register that switch the claim-off flag or change the mask, each in the same clock as a cycle strobe. A behavioural model commits its register writes after it has evaluated the cycle. Judged on every clock, `claim` and `xlat_addr` must reflect the settings that were in force before the write.

// File: rtl/win_pkg.sv
package win_pkg;

    localparam int ADDR_W   = 32;
    localparam int PAGE_LSB = 12;
    localparam int TAG_W    = ADDR_W - PAGE_LSB;

    localparam logic [TAG_W-1:0] MASK_RESET = 20'hFF000;

    typedef enum logic [1:0] {
        SEL_BASE  = 2'd0,
        SEL_LIMIT = 2'd1,
        SEL_XLATE = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [TAG_W-1:0] base;
        logic [TAG_W-1:0] mask;
        logic             claim_off;
        logic [TAG_W-1:0] xlate;
    } win_cfg_t;

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] addr;
    } xlat_res_t;

    function automatic logic [ADDR_W-1:0] widen_tag(input logic [TAG_W-1:0] tag);
        return {tag, {PAGE_LSB{1'b0}}};
    endfunction

endpackage

// File: rtl/win_regs.sv
module win_regs
    import win_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        sel,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] rdata,
    output win_cfg_t          cfg
);

    logic [TAG_W-1:0] base_q;
    logic [TAG_W-1:0] mask_q;
    logic             off_q;
    logic [TAG_W-1:0] xlate_q;
    reg_sel_e         sel_e;

    assign sel_e = reg_sel_e'(sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            mask_q  <= MASK_RESET;
            off_q   <= 1'b0;
            xlate_q <= '0;
        end else if (wr_en) begin
            unique case (sel_e)
                SEL_BASE:  base_q <= wdata[ADDR_W-1:PAGE_LSB] & mask_q;
                SEL_LIMIT: begin
                    mask_q <= wdata[ADDR_W-1:PAGE_LSB];
                    off_q  <= wdata[0];
                end
                SEL_XLATE: xlate_q <= wdata[ADDR_W-1:PAGE_LSB];
                default:   ;
            endcase
        end
    end

    always_comb begin
        unique case (sel_e)
            SEL_BASE:  rdata = widen_tag(base_q & mask_q);
            SEL_LIMIT: rdata = widen_tag(mask_q) | {{(ADDR_W-1){1'b0}}, off_q};
            SEL_XLATE: rdata = widen_tag(xlate_q);
            default:   rdata = '0;
        endcase
    end

    always_comb begin
        cfg.base      = base_q;
        cfg.mask      = mask_q;
        cfg.claim_off = off_q;
        cfg.xlate     = xlate_q;
    end

endmodule

// File: rtl/win_match.sv
module win_match
    import win_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  win_cfg_t          cfg,
    output xlat_res_t         res
);

    logic [TAG_W-1:0] bit_ok;
    logic [TAG_W-1:0] out_tag;

    for (genvar i = 0; i < TAG_W; i++) begin : g_bit
        assign bit_ok[i]  = ~cfg.mask[i] | (addr[PAGE_LSB+i] == cfg.base[i]);
        assign out_tag[i] = cfg.mask[i] ? cfg.xlate[i] : addr[PAGE_LSB+i];
    end

    always_comb begin
        res.hit  = (&bit_ok) & (|cfg.mask);
        res.addr = {out_tag, addr[PAGE_LSB-1:0]};
    end

endmodule

// File: rtl/win_claim_stage.sv
module win_claim_stage
    import win_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic              claim_off,
    input  xlat_res_t         res,
    output logic              claim,
    output logic [ADDR_W-1:0] addr_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            claim    <= 1'b0;
            addr_out <= '0;
        end else begin
            claim <= valid & res.hit & ~claim_off;
            if (valid) begin
                addr_out <= res.addr;
            end
        end
    end

endmodule

// File: rtl/inbound_window_xlate.sv
module inbound_window_xlate
    import win_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        cyc_valid,
    input  logic [31:0] cyc_addr,
    output logic        claim,
    output logic [31:0] xlat_addr
);

    win_cfg_t  cfg;
    xlat_res_t res;

    win_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr),
        .sel   (reg_sel),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    win_match u_match (
        .addr (cyc_addr),
        .cfg  (cfg),
        .res  (res)
    );

    win_claim_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .valid     (cyc_valid),
        .claim_off (cfg.claim_off),
        .res       (res),
        .claim     (claim),
        .addr_out  (xlat_addr)
    );

endmodule

// File: rtl/win_chk.sv
module win_chk
    import win_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [1:0]  reg_sel,
    input logic [31:0] reg_rdata,
    input logic        cyc_valid,
    input logic [31:0] cyc_addr,
    input logic        claim,
    input logic [31:0] xlat_addr,
    input win_cfg_t    cfg
);

    // R2
    base_read_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == 2'd0) |-> ((reg_rdata & ~widen_tag(cfg.mask)) == 32'h0));

    // R3
    empty_mask_no_claim_chk: assert property (@(posedge clk) disable iff (rst)
        claim |-> $past(|cfg.mask));

    // R4
    limit_reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == 2'd1) |-> (reg_rdata[11:1] == 11'h0));

    // R5
    claim_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        claim |-> $past(cyc_valid));

    // R6
    claim_off_chk: assert property (@(posedge clk) disable iff (rst)
        claim |-> !$past(cfg.claim_off));

    // R7
    low_bits_pass_chk: assert property (@(posedge clk) disable iff (rst)
        $past(cyc_valid) |-> (xlat_addr[11:0] == $past(cyc_addr[11:0])));

    // R10
    unused_sel_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == 2'd3) |-> (reg_rdata == 32'h0));

endmodule

bind inbound_window_xlate win_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_sel   (reg_sel),
    .reg_rdata (reg_rdata),
    .cyc_valid (cyc_valid),
    .cyc_addr  (cyc_addr),
    .claim     (claim),
    .xlat_addr (xlat_addr),
    .cfg       (cfg)
);

// File: tb/sim_inbound_window_xlate.sv
module sim_inbound_window_xlate;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        cyc_valid = 1'b0;
    logic [31:0] cyc_addr = 32'h0;
    logic        claim;
    logic [31:0] xlat_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    inbound_window_xlate u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cyc_valid(cyc_valid), .cyc_addr(cyc_addr),
        .claim(claim), .xlat_addr(xlat_addr)
    );

    always #(PERIOD/2) clk = ~clk;

    // behavioural reference model
    logic [31:0] m_base, m_lim, m_xl, e_xl;
    logic        e_claim, e_v;

    function automatic logic [31:0] mmask(input logic [31:0] lim);
        return lim & 32'hFFFFF000;
    endfunction

    function automatic logic [31:0] m_read(input logic [1:0] s);
        case (s)
            2'd0:    return m_base & mmask(m_lim);
            2'd1:    return m_lim;
            2'd2:    return m_xl;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_base <= 0; m_lim <= 32'hFF000000; m_xl <= 0;
            e_claim <= 0; e_v <= 0; e_xl <= 0;
        end else begin
            logic [31:0] mk;
            mk = mmask(m_lim);
            e_v <= cyc_valid;
            e_claim <= cyc_valid && (mk != 0) && ((cyc_addr & mk) == (m_base & mk)) && !m_lim[0];
            if (cyc_valid) e_xl <= (m_xl & mk) | (cyc_addr & ~mk);
            if (reg_wr) begin
                case (reg_sel)
                    2'd0: m_base <= reg_wdata & mk;
                    2'd1: m_lim  <= reg_wdata & 32'hFFFFF001;
                    2'd2: m_xl   <= reg_wdata & 32'hFFFFF000;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R5/R6/R9 claim", {31'h0, claim}, {31'h0, e_claim});
            if (e_v) check("R7/R8/R9 xlat_addr", xlat_addr, e_xl);
            case (reg_sel)
                2'd0: check("R2 base read", reg_rdata, m_read(2'd0));
                2'd1: check("R4 limit read", reg_rdata, m_read(2'd1));
                2'd2: check("R8 xlate read", reg_rdata, m_read(2'd2));
                default: check("R10 unused read", reg_rdata, 32'h0);
            endcase
        end
    end

    task automatic drive(input logic wr, input logic [1:0] s, input logic [31:0] d,
                         input logic v, input logic [31:0] a);
        @(posedge clk); #2;
        reg_wr = wr; reg_sel = s; reg_wdata = d; cyc_valid = v; cyc_addr = a;
    endtask

    task automatic idle();
        drive(1'b0, reg_sel, 32'h0, 1'b0, 32'h0);
    endtask

    task automatic rd_expect(input string tag, input logic [1:0] s, input logic [31:0] exp);
        drive(1'b0, s, 32'h0, 1'b0, 32'h0);
        #1 check(tag, reg_rdata, exp);
    endtask

    task automatic cyc_expect(input string tag, input logic [31:0] a,
                              input logic exp_c, input logic [31:0] exp_a);
        drive(1'b0, reg_sel, 32'h0, 1'b1, a);
        idle();
        #1 check({tag, " claim"}, {31'h0, claim}, {31'h0, exp_c});
        if (exp_c) check({tag, " addr"}, xlat_addr, exp_a);
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // R1 reset values
        rd_expect("R1 base reset", 2'd0, 32'h0);
        rd_expect("R1 limit reset", 2'd1, 32'hFF000000);
        rd_expect("R1 xlate reset", 2'd2, 32'h0);
        // R4 reserved limit bits
        drive(1'b1, 2'd1, 32'hFFF00FFE, 1'b0, 0);
        rd_expect("R4 limit reserved", 2'd1, 32'hFFF00000);
        // R2 masked base write
        drive(1'b1, 2'd0, 32'h12345678, 1'b0, 0);
        rd_expect("R2 base masked", 2'd0, 32'h12300000);
        // R8 translate low bits
        drive(1'b1, 2'd2, 32'hABCDEFFF, 1'b0, 0);
        rd_expect("R8 xlate low zero", 2'd2, 32'hABCDE000);
        // R5 / R7 hit and miss; R8 low xlate bits ignored
        cyc_expect("R5 R7 R8 hit", 32'h123ABCDE, 1'b1, 32'hABCABCDE);
        cyc_expect("R5 miss", 32'h22300000, 1'b0, 32'h0);
        // R6 claim-off
        drive(1'b1, 2'd1, 32'hFFF00001, 1'b0, 0);
        rd_expect("R4 limit bit0", 2'd1, 32'hFFF00001);
        cyc_expect("R6 disabled", 32'h12300040, 1'b0, 32'h0);
        // R3 empty mask
        drive(1'b1, 2'd1, 32'h0, 1'b0, 0);
        drive(1'b1, 2'd0, 32'hFFFFFFFF, 1'b0, 0);
        rd_expect("R3 base no effect", 2'd0, 32'h0);
        cyc_expect("R3 no claim", 32'h0, 1'b0, 32'h0);
        // R9 write and cycle in the same clock
        drive(1'b1, 2'd1, 32'hFF000000, 1'b0, 0);
        drive(1'b1, 2'd0, 32'h55000000, 1'b1, 32'h55000010);
        idle();
        #1 check("R9 old base used", {31'h0, claim}, 32'h0);
        cyc_expect("R9 new base", 32'h55000010, 1'b1, 32'hAB000010);
        drive(1'b1, 2'd1, 32'hFF000001, 1'b1, 32'h55000020);
        idle();
        #1 check("R9 old enable used", {31'h0, claim}, 32'h1);
        // R10 unused select
        drive(1'b1, 2'd3, 32'hFFFFFFFF, 1'b0, 0);
        rd_expect("R10 unused", 2'd3, 32'h0);
        rd_expect("R10 limit kept", 2'd1, 32'hFF000001);
        // mixed traffic, judged by the per-clock model
        lf = 32'hACE1_2345;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            drive(lf[3] & lf[4], lf[6:5], (lf[7] ? {lf[31:12], 12'h000} : lf) & ((lf[6:5]==2'd1) ? 32'hFFFFFFFE | {31'h0, lf[8] & lf[9]} : 32'hFFFFFFFF),
                  lf[10], {lf[2] ? 8'h55 : lf[31:24], lf[23:0]});
        end
        idle(); idle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule